// File: doc/BRIEF.md
# Receive-Threshold Hardware Flow Controller

This block does automatic request-to-send / clear-to-send pacing for one asynchronous serial channel. On the receive side it reads the fill level of the receive FIFO and drives an active-low request output (`rts_n`). The output turns off once the FIFO climbs to a programmable halt threshold. It turns on again only when the level has drained to a separate, lower resume threshold. While the level sits between the two thresholds, the output keeps its previous state. Both thresholds are packed into one 8-bit threshold byte: the halt count is in the low nibble and the resume count is in the high nibble. Each nibble is scaled by four to give a byte count, so each threshold runs from 0 to 60 bytes in steps of four.

On the transmit side the block passes the active-low clear input through a synchronizer. It produces `tx_permit`, which the serializer samples before it begins each new character. A character already on the line is never cut short. Both automatic functions have their own enable bit in a feature control byte. When automatic request is off, `rts_n` follows a modem-control bit written by the host. Whenever the request pin or the synchronized clear pin rises from low to high, the block emits a one-cycle `cos_pulse` that interrupt logic can latch.

Top module: `hw_flow_ctrl`

## Requirements
- R1: During reset, `rts_n` is 1, `cos_pulse` is 0 and the synchronized clear state is "deasserted", so `tx_permit` is 0 when automatic clear gating is on.
- R2: The halt threshold is 4 × `thr_reg[3:0]` bytes and the resume threshold is 4 × `thr_reg[7:4]` bytes.
- R3: With automatic request on (`feat_ctl[6]`=1) and the FIFO level below the halt threshold and at or below the resume threshold, `rts_n` is 0 one clock edge later.
- R4: With automatic request on, a FIFO level at or above the halt threshold makes `rts_n` 1 one clock edge later.
- R5: With automatic request on and the level strictly between the resume and halt thresholds, `rts_n` keeps its previous value.
- R6: After a halt, `rts_n` returns to 0 one edge after the level falls to the resume threshold or below. A level one step above the resume threshold does not release it.
- R7: When the level meets both conditions at once (halt threshold ≤ level ≤ resume threshold, including a halt threshold of 0), the halt condition wins and `rts_n` is 1.
- R8: With automatic request off (`feat_ctl[6]`=0), `rts_n` equals the inverse of `host_rts` one edge later, whatever the FIFO level.
- R9: With automatic clear gating on (`feat_ctl[7]`=1), `tx_permit` follows the inverse of `cts_n` after SYNC_STAGES (default 2) clock edges.
- R10: While `tx_in_char` is 1 (a character is on the line), `tx_permit` is 1 even when the clear input is deasserted.
- R11: With automatic clear gating off, `tx_permit` is 1 regardless of `cts_n`.
- R12: `cos_pulse` is 1 for exactly the one cycle after `rts_n` or the synchronized clear input rises from 0 to 1. A falling edge on either produces no pulse.
- R13: Bits 5:0 of `feat_ctl` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_ctl | input | 8 | Feature byte: bit 7 enables clear gating, bit 6 enables automatic request |
| thr_reg | input | 8 | Threshold byte: [3:0] halt nibble, [7:4] resume nibble |
| rx_level | input | LVL_W (7) | Current receive FIFO fill level in bytes |
| host_rts | input | 1 | Host modem-control request bit (1 = assert) |
| cts_n | input | 1 | Active-low clear-to-send input pin, asynchronous |
| tx_in_char | input | 1 | Serializer is in the middle of a character |
| rts_n | output | 1 | Active-low request-to-send output, registered |
| tx_permit | output | 1 | Serializer may begin a new character |
| cos_pulse | output | 1 | One-cycle pulse on a low-to-high change of `rts_n` or of the synchronized clear input |

## Verification
The request side is driven through level sweeps that approach each threshold from both sides: exactly at the halt count, one step below it, one above the resume count, and exactly at the resume count. Each sweep is run under two different threshold bytes, which separates correct nibble placement and scaling from a swapped or unscaled field. Dedicated patterns cover a halt threshold of zero and a resume threshold above the halt threshold, to confirm that halt has priority. Host-driven mode is tested with a FIFO level that would halt, which shows the level is really ignored. The clear side is tested by toggling the input with and without a character in flight and with gating disabled, and by counting synchronizer edges before `tx_permit` changes. On both pins, the pulse is checked on rising edges and confirmed absent on falling ones.

// File: rtl/flow_pkg.sv
package flow_pkg;
  // feature byte bit positions (decoded by the host register block)
  localparam int CTS_EN_BIT = 7;
  localparam int RTS_EN_BIT = 6;
  localparam logic [7:0] CTL_USED = 8'(1 << CTS_EN_BIT) | 8'(1 << RTS_EN_BIT);

  // threshold nibble geometry
  localparam int TH_W     = 4;
  localparam int STEP_SH  = 2;            // nibble * 4
  localparam int TBYTES_W = TH_W + STEP_SH;

  function automatic logic [TBYTES_W-1:0] nib_to_bytes(input logic [TH_W-1:0] nib);
    return {nib, {STEP_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
  import flow_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             host_assert,
  input  logic [LVL_W-1:0] level,
  input  logic [7:0]       thr,
  output logic             rts_n,
  output logic             halted,
  output logic             at_halt,
  output logic             at_resume
);
  localparam int CW = (LVL_W > TBYTES_W) ? LVL_W + 1 : TBYTES_W + 1;

  logic [CW-1:0] lvl_x, halt_x, res_x;
  logic          halted_d;

  assign lvl_x  = CW'(level);
  assign halt_x = CW'(nib_to_bytes(thr[TH_W-1:0]));
  assign res_x  = CW'(nib_to_bytes(thr[2*TH_W-1:TH_W]));

  assign at_halt   = (lvl_x >= halt_x);
  assign at_resume = (lvl_x <= res_x);

  // halt has priority; between thresholds the state holds
  always_comb begin
    if (at_halt)        halted_d = 1'b1;
    else if (at_resume) halted_d = 1'b0;
    else                halted_d = halted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      rts_n  <= 1'b1;
    end else begin
      halted <= halted_d;
      rts_n  <= auto_en ? halted_d : ~host_assert;
    end
  end
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= sig;
  end

  assign pulse = sig & ~prev;
endmodule

// File: rtl/hw_flow_ctrl.sv
module hw_flow_ctrl
  import flow_pkg::*;
#(
  parameter int LVL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       feat_ctl,
  input  logic [7:0]       thr_reg,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             host_rts,
  input  logic             cts_n,
  input  logic             tx_in_char,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             cos_pulse
);
  logic auto_rts_en, auto_cts_en;
  logic cts_sync_n;
  logic halted, at_halt, at_resume;
  logic rts_rise, cts_rise;
  logic unused_ctl;

  assign auto_rts_en = feat_ctl[RTS_EN_BIT];
  assign auto_cts_en = feat_ctl[CTS_EN_BIT];
  assign unused_ctl  = ^(feat_ctl & ~CTL_USED);

  flow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_sync_n)
  );

  rts_hyst #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .host_assert(host_rts),
    .level(rx_level), .thr(thr_reg), .rts_n(rts_n), .halted(halted),
    .at_halt(at_halt), .at_resume(at_resume)
  );

  // character start gate: an in-flight character always completes
  assign tx_permit = ~auto_cts_en | ~cts_sync_n | tx_in_char;

  rise_pulse u_rts_edge (.clk(clk), .rst_n(rst_n), .sig(rts_n),      .pulse(rts_rise));
  rise_pulse u_cts_edge (.clk(clk), .rst_n(rst_n), .sig(cts_sync_n), .pulse(cts_rise));

  assign cos_pulse = rts_rise | cts_rise;
endmodule

// File: rtl/hw_flow_ctrl_chk.sv
module hw_flow_ctrl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       feat_ctl,
  input logic [7:0]       thr_reg,
  input logic [LVL_W-1:0] rx_level,
  input logic             host_rts,
  input logic             tx_in_char,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             cos_pulse,
  input logic             halted
);
  int lvl_i, halt_i, res_i;
  assign lvl_i  = int'(rx_level);
  assign halt_i = 4 * int'(thr_reg[3:0]);
  assign res_i  = 4 * int'(thr_reg[7:4]);

  // R4, R7: at or above halt -> deasserted next edge
  a_r4_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ctl[6] && lvl_i >= halt_i) |=> rts_n);

  // R3, R6: below halt and at/below resume -> asserted next edge
  a_r6_resume_on: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ctl[6] && lvl_i < halt_i && lvl_i <= res_i) |=> !rts_n);

  // R5: hysteresis band keeps the halt state
  a_r5_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i < halt_i && lvl_i > res_i) |=> (halted == $past(halted)));

  // R8: host mode follows host bit
  a_r8_host_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_ctl[6]) |=> (rts_n == !$past(host_rts)));

  // R10: in-flight character is never stopped
  a_r10_in_char: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_char |-> tx_permit);

  // R11: gating off always permits
  a_r11_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_ctl[7]) |-> tx_permit);

  // R12: request rising edge is reported
  a_r12_rts_cos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> cos_pulse);
endmodule

bind hw_flow_ctrl hw_flow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .feat_ctl(feat_ctl), .thr_reg(thr_reg),
  .rx_level(rx_level), .host_rts(host_rts), .tx_in_char(tx_in_char),
  .rts_n(rts_n), .tx_permit(tx_permit), .cos_pulse(cos_pulse), .halted(halted)
);

// File: tb/sim_hw_flow_ctrl.sv
`timescale 1ns/1ps
module sim_hw_flow_ctrl;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] feat_ctl = 8'hC0;
  logic [7:0] thr_reg  = 8'h48;
  logic [LVL_W-1:0] rx_level = '0;
  logic host_rts = 1'b0, cts_n = 1'b0, tx_in_char = 1'b0;
  logic rts_n, tx_permit, cos_pulse;

  always #2.5 clk = ~clk;   // 200 MHz

  hw_flow_ctrl #(.LVL_W(LVL_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .feat_ctl(feat_ctl), .thr_reg(thr_reg),
    .rx_level(rx_level), .host_rts(host_rts), .cts_n(cts_n),
    .tx_in_char(tx_in_char), .rts_n(rts_n), .tx_permit(tx_permit),
    .cos_pulse(cos_pulse)
  );

  typedef struct {
    int         due;
    int         req;
    logic [2:0] mask;   // {rts, permit, cos}
    logic [2:0] expv;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check3(int req, logic [2:0] mask, logic [2:0] expv);
    logic [2:0] act;
    act = {rts_n, tx_permit, cos_pulse};
    n_chk++;
    if ((act & mask) !== (expv & mask)) begin
      n_fail++;
      $display("FAIL R%0d cyc %0d: {rts_n,permit,cos} actual %b expected %b (mask %b)",
               req, cyc, act, expv, mask);
    end
  endtask

  // driver side: push an expectation d cycles after now
  task automatic expect_at(int d, int req, logic [2:0] mask, logic [2:0] expv);
    exp_t e;
    e.due = cyc + d; e.req = req; e.mask = mask; e.expv = expv;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pop and compare at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check3(e.req, e.mask, e.expv);
    end
  end

  localparam logic [2:0] M_R = 3'b100, M_P = 3'b010, M_C = 3'b001;

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check3(1, M_R | M_C | M_P, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3: level 0 with halt 32 / resume 16 -> asserted; clear sync -> permit
    expect_at(1, 3, M_R, 3'b000);
    expect_at(2, 3, M_R | M_P | M_C, 3'b010);
    tick(3);

    // R4: exactly at halt (32) -> deasserted, rising edge pulse (R12)
    rx_level = 7'd32;
    expect_at(1, 4, M_R | M_C, 3'b101);
    expect_at(2, 12, M_R | M_C, 3'b100);
    tick(3);

    // R5: band 20 holds deasserted
    rx_level = 7'd20;
    expect_at(1, 5, M_R, 3'b100);
    expect_at(3, 5, M_R, 3'b100);
    tick(4);

    // R6: one above resume (17) still held, at resume (16) releases, no pulse (R12)
    rx_level = 7'd17;
    expect_at(1, 6, M_R, 3'b100);
    tick(2);
    rx_level = 7'd16;
    expect_at(1, 6, M_R | M_C, 3'b000);
    tick(2);

    // R5: band from the asserted side keeps asserted; 31 is one below halt
    rx_level = 7'd28;
    expect_at(2, 5, M_R, 3'b000);
    tick(3);
    rx_level = 7'd31;
    expect_at(1, 4, M_R, 3'b000);
    tick(2);
    rx_level = 7'd32;
    expect_at(1, 4, M_R, 3'b100);
    tick(3);

    // R2: new thresholds halt 40 (0xA), resume 12 (0x3)
    thr_reg = 8'h3A;
    expect_at(1, 2, M_R, 3'b100);
    tick(2);
    rx_level = 7'd13;
    expect_at(1, 2, M_R, 3'b100);
    tick(2);
    rx_level = 7'd12;
    expect_at(1, 2, M_R, 3'b000);
    tick(2);
    rx_level = 7'd39;
    expect_at(1, 2, M_R, 3'b000);
    tick(2);
    rx_level = 7'd40;
    expect_at(1, 2, M_R, 3'b100);
    tick(3);

    // R7: halt 0 wins at level 0; halt 4 vs resume 60 at level 10
    thr_reg = 8'h48; rx_level = 7'd0;
    expect_at(1, 7, M_R, 3'b000);
    tick(3);
    thr_reg = 8'h50;
    expect_at(1, 7, M_R, 3'b100);
    tick(3);
    thr_reg = 8'h48;
    expect_at(1, 7, M_R, 3'b000);
    tick(3);
    thr_reg = 8'hF1; rx_level = 7'd10;
    expect_at(1, 7, M_R, 3'b100);
    tick(3);

    // R8: host mode ignores level
    feat_ctl = 8'h80; host_rts = 1'b1;
    expect_at(1, 8, M_R, 3'b000);
    tick(2);
    host_rts = 1'b0;
    expect_at(1, 8, M_R | M_C, 3'b101);
    expect_at(2, 12, M_C, 3'b000);
    tick(3);
    host_rts = 1'b1; rx_level = 7'd60;
    expect_at(1, 8, M_R, 3'b000);
    tick(2);

    // R13: low feature bits set, still host mode, still permitting
    feat_ctl = 8'hBF; host_rts = 1'b1;
    expect_at(1, 13, M_R | M_P, 3'b010);
    tick(2);
    feat_ctl = 8'hFF; thr_reg = 8'h48; rx_level = 7'd0;
    expect_at(1, 13, M_R | M_P, 3'b010);
    tick(3);
    feat_ctl = 8'hC0;

    // R9: clear deasserts -> permit drops after two edges, pulse (R12)
    cts_n = 1'b1;
    expect_at(1, 9, M_P, 3'b010);
    expect_at(2, 9, M_P | M_C, 3'b001);
    expect_at(3, 12, M_C, 3'b000);
    tick(4);
    cts_n = 1'b0;
    expect_at(1, 9, M_P, 3'b000);
    expect_at(2, 9, M_P | M_C, 3'b010);
    tick(3);

    // R10: in-flight character keeps permit
    cts_n = 1'b1;
    expect_at(3, 9, M_P, 3'b000);
    tick(4);
    tx_in_char = 1'b1;
    expect_at(0, 10, M_P, 3'b010);
    tick(2);
    tx_in_char = 1'b0;
    expect_at(0, 10, M_P, 3'b000);
    tick(2);

    // R11: gating off
    feat_ctl = 8'h40;
    expect_at(0, 11, M_P, 3'b010);
    tick(2);
    cts_n = 1'b0; tick(3); cts_n = 1'b1;
    expect_at(3, 11, M_P, 3'b010);
    tick(5);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule